// File: doc/BRIEF.md
# Streaming CRC-16 Checksum Inserter

This block computes a 16-bit cyclic redundancy check over framed messages that arrive as a stream of `DATA_W`-bit words, one word per valid cycle. Each frame is marked by start, end and valid strobes. The sender appends a 16-bit padding field to every message, taking up `16/DATA_W` words. The block passes the message words through unchanged and writes the ones' complement of the checksum into the padding words. The start, end and valid strobes come out aligned with the output data.

The checksum register starts from all ones on each start word. It uses the generator x^16 + x^12 + x^5 + 1 in direct form: each message bit is XORed into the register's top end, and the arithmetic adds no zero bits. Several bits are absorbed per clock. Every output lags its input by a fixed `16/DATA_W + 2` cycles.

Top module: `crc16_stream_gen`

## Requirements
- R1: The checksum is the CRC of the message words only, with generator 0x1021 in direct form. Within a word, bit `DATA_W-1` is the earliest bit. A message bit XORs with register bit 15, the register shifts left, and it XORs with 0x1021 when that result is 1.
- R2: Each valid start word loads the register with 0xFFFF before that word is absorbed.
- R3: The inserted checksum is the final register value XORed with 0xFFFF.
- R4: The 32-bit message 0x50000300 (bit 31 first) gives the inserted checksum 0x5B57.
- R5: Each valid input word produces exactly one output word with valid high. That word, with its start and end flags, appears `16/DATA_W + 2` clock edges after the edge that samples the input.
- R6: Message words leave the block unchanged.
- R7: The final `16/DATA_W` valid words of a frame, ending with the end word, carry the checksum, most significant slice first. The data the sender puts in those words has no effect on the output.
- R8: A cycle with valid low does not advance the checksum, and it gives valid low at the output `16/DATA_W + 2` cycles later. Start, end and data are ignored in that cycle.
- R9: A start word that arrives inside an unfinished frame restarts the checksum. The words already received from the abandoned frame are still output unchanged, with end low.
- R10: From the first clock edge with reset high, the output valid, start and end strobes are low, and they stay low until input words have had time to reach the output.
- R11: `DATA_W` is one of 16, 8, 4, 2 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_start | input | 1 | First word of a frame |
| in_end | input | 1 | Last padding word of a frame |
| in_data | input | DATA_W | Input word, MSB earliest |
| out_valid | output | 1 | Output word present |
| out_start | output | 1 | First output word of a frame |
| out_end | output | 1 | Last checksum word of a frame |
| out_data | output | DATA_W | Message word or checksum slice |

## Verification
The assertions and the design take three things for granted. Every frame holds at least one message word. Its `16/DATA_W` padding words arrive on consecutive valid cycles. Start and end only mean something when valid is high. The stimulus follows these rules. It places idle cycles, filled with random start, end and data values, only before and between message words and between frames. Every padding group is driven without a break. Under these rules, the assertions check three things: end words land on checksum slots, the checksum register stays still on idle and padding words, and message data moves one stage unchanged on its way to the output.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int unsigned  CRC_W      = 16;
    localparam logic [15:0]  CRC_POLY   = 16'h1021;
    localparam logic [15:0]  CRC_SEED   = 16'hFFFF;
    localparam logic [15:0]  CRC_XOROUT = 16'hFFFF;
    localparam int unsigned  SLOT_W     = 4;

    // Control bits that travel with each word down the delay line.
    typedef struct packed {
        logic              vld;
        logic              sop;
        logic              eop;
        logic              pad;
        logic [SLOT_W-1:0] slot;
    } lane_ctl_t;

    // Absorb the top nbits of a left-aligned word, earliest bit first.
    function automatic logic [15:0] crc_advance(input logic [15:0] state,
                                                input logic [15:0] word,
                                                input int unsigned nbits);
        logic [15:0] s;
        logic        fb;
        s = state;
        for (int i = 0; i < 16; i++) begin
            if (i < int'(nbits)) begin
                fb = s[15] ^ word[15-i];
                s  = {s[14:0], 1'b0};
                if (fb) s = s ^ CRC_POLY;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/crc16_stage_line.sv
module crc16_stage_line
    import crc16_pkg::*;
#(
    parameter int unsigned W   = 8,
    parameter int unsigned PADW = 2,
    parameter int unsigned LAT = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_vld,
    input  logic             in_sop,
    input  logic             in_eop,
    input  logic [W-1:0]     in_data,
    output lane_ctl_t        tap_ctl,
    output logic [W-1:0]     tap_data,
    output lane_ctl_t        fin_ctl,
    output logic [W-1:0]     fin_data
);

    lane_ctl_t    ctl_q [LAT];
    logic [W-1:0] dat_q [LAT];
    logic         close_frame;

    assign close_frame = in_vld & in_eop;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(LAT); k++) begin
                ctl_q[k] <= '0;
            end
        end else begin
            ctl_q[0].vld  <= in_vld;
            ctl_q[0].sop  <= in_vld & in_sop;
            ctl_q[0].eop  <= close_frame;
            ctl_q[0].pad  <= close_frame;
            ctl_q[0].slot <= SLOT_W'(PADW - 1);
            for (int k = 1; k < int'(LAT); k++) begin
                ctl_q[k] <= ctl_q[k-1];
            end
            // The end word reveals the padding words still in flight.
            if (close_frame) begin
                for (int k = 1; k < int'(PADW); k++) begin
                    ctl_q[k].pad  <= 1'b1;
                    ctl_q[k].slot <= SLOT_W'(int'(PADW) - 1 - k);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        dat_q[0] <= in_data;
        for (int k = 1; k < int'(LAT); k++) begin
            dat_q[k] <= dat_q[k-1];
        end
    end

    assign tap_ctl  = ctl_q[PADW];
    assign tap_data = dat_q[PADW];
    assign fin_ctl  = ctl_q[LAT-1];
    assign fin_data = dat_q[LAT-1];

endmodule

// File: rtl/crc16_accum.sv
module crc16_accum
    import crc16_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tap_vld,
    input  logic         tap_sop,
    input  logic         tap_pad,
    input  logic [W-1:0] tap_data,
    output logic [15:0]  crc_q
);

    logic [15:0] aligned;
    logic [15:0] base;

    always_comb begin
        aligned          = '0;
        aligned[15 -: W] = tap_data;
        base             = tap_sop ? CRC_SEED : crc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q <= CRC_SEED;
        end else if (tap_vld && !tap_pad) begin
            crc_q <= crc_advance(base, aligned, W);
        end
    end

endmodule

// File: rtl/crc16_insert.sv
module crc16_insert
    import crc16_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  lane_ctl_t    fin_ctl,
    input  logic [W-1:0] fin_data,
    input  logic [15:0]  crc_q,
    output logic         out_valid,
    output logic         out_start,
    output logic         out_end,
    output logic [W-1:0] out_data
);

    logic [15:0] chk;
    logic [15:0] chk_shift;

    always_comb begin
        chk       = crc_q ^ CRC_XOROUT;
        chk_shift = chk << (int'(fin_ctl.slot) * int'(W));
        out_valid = fin_ctl.vld;
        out_start = fin_ctl.sop;
        out_end   = fin_ctl.eop;
        out_data  = fin_ctl.pad ? chk_shift[15 -: W] : fin_data;
    end

endmodule

// File: rtl/crc16_stream_gen.sv
module crc16_stream_gen
    import crc16_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_start,
    input  logic              in_end,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic              out_start,
    output logic              out_end,
    output logic [DATA_W-1:0] out_data
);

    localparam int unsigned PAD_WORDS = CRC_W / DATA_W;
    localparam int unsigned LATENCY   = PAD_WORDS + 2;

    lane_ctl_t         tap_ctl;
    lane_ctl_t         fin_ctl;
    logic [DATA_W-1:0] tap_data;
    logic [DATA_W-1:0] fin_data;
    logic [15:0]       crc_q;

    crc16_stage_line #(.W(DATA_W), .PADW(PAD_WORDS), .LAT(LATENCY)) u_line (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_valid),
        .in_sop   (in_start),
        .in_eop   (in_end),
        .in_data  (in_data),
        .tap_ctl  (tap_ctl),
        .tap_data (tap_data),
        .fin_ctl  (fin_ctl),
        .fin_data (fin_data)
    );

    crc16_accum #(.W(DATA_W)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .tap_vld  (tap_ctl.vld),
        .tap_sop  (tap_ctl.sop),
        .tap_pad  (tap_ctl.pad),
        .tap_data (tap_data),
        .crc_q    (crc_q)
    );

    crc16_insert #(.W(DATA_W)) u_insert (
        .fin_ctl   (fin_ctl),
        .fin_data  (fin_data),
        .crc_q     (crc_q),
        .out_valid (out_valid),
        .out_start (out_start),
        .out_end   (out_end),
        .out_data  (out_data)
    );

endmodule

// File: rtl/crc16_stream_chk.sv
module crc16_stream_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         out_valid,
    input logic         out_start,
    input logic         out_end,
    input logic         tap_vld,
    input logic         tap_pad,
    input logic [W-1:0] tap_data,
    input logic         fin_vld,
    input logic         fin_eop,
    input logic         fin_pad,
    input logic [W-1:0] fin_data,
    input logic [15:0]  crc_q
);

    // R10: reset silences the output strobes on the following cycle.
    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_start && !out_end));

    // R5: frame marks only ride on valid output words.
    p_marks_valid_r5: assert property (@(posedge clk) disable iff (rst)
        (out_start || out_end) |-> out_valid);

    // R7: an end word at the output always sits on a checksum slot.
    p_end_on_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (fin_vld && fin_eop) |-> fin_pad);

    // R8: an idle word at the tap leaves the checksum register untouched.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !tap_vld |=> $stable(crc_q));

    // R7: padding words are not absorbed into the checksum.
    p_pad_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tap_vld && tap_pad) |=> $stable(crc_q));

    // R6: a message word moves from the tap to the output unchanged.
    p_msg_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (fin_vld && !fin_pad && $past(tap_vld)) |-> (fin_data == $past(tap_data)));

endmodule

bind crc16_stream_gen crc16_stream_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_start (out_start),
    .out_end   (out_end),
    .tap_vld   (tap_ctl.vld),
    .tap_pad   (tap_ctl.pad),
    .tap_data  (tap_data),
    .fin_vld   (fin_ctl.vld),
    .fin_eop   (fin_ctl.eop),
    .fin_pad   (fin_ctl.pad),
    .fin_data  (fin_data),
    .crc_q     (crc_q)
);

// File: tb/crc16_stream_gen_tb_top.sv
`timescale 1ns/1ps
module crc16_stream_gen_tb_top;

    localparam int W   = 8;          // R11: one of the legal widths
    localparam int P   = 16 / W;
    localparam int LAT = P + 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0, in_start = 1'b0, in_end = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid, out_start, out_end;
    logic [W-1:0] out_data;

    int unsigned cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          run = 1'b0;
    bit          done = 1'b0;

    typedef struct {
        int unsigned  cyc;
        logic [W-1:0] data;
        bit           s;
        bit           e;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] msg_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    crc16_stream_gen #(.DATA_W(W)) dut_i (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_start (in_start), .in_end (in_end), .in_data (in_data),
        .out_valid (out_valid), .out_start (out_start), .out_end (out_end), .out_data (out_data)
    );

    // Reference checksum: serial, direct form, seed all ones, complemented.
    function automatic logic [15:0] ref_chk();
        logic [15:0] r = 16'hFFFF;
        logic        top;
        foreach (msg_q[i]) begin
            for (int b = W - 1; b >= 0; b--) begin
                top = r[15] ^ msg_q[i][b];
                r   = r << 1;
                if (top) r = r ^ 16'h1021;
            end
        end
        return ~r;
    endfunction

    task automatic drive(input bit v, input bit s, input bit e, input logic [W-1:0] d,
                         output int unsigned at);
        @(negedge clk);
        in_valid = v; in_start = s; in_end = e; in_data = d;
        at = cyc;
    endtask

    // R8: idle cycle with random control and data values.
    task automatic idle();
        int unsigned at;
        drive(1'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), W'($urandom), at);
    endtask

    task automatic push(input int unsigned at, input logic [W-1:0] d, input bit s,
                        input bit e, input string tag);
        exp_t it;
        it.cyc = at + LAT; it.data = d; it.s = s; it.e = e; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic send_frame(input bit gaps, input logic [15:0] pad_fill,
                              input string mtag, input string ctag);
        logic [15:0] chk;
        int unsigned at;
        chk = ref_chk();
        foreach (msg_q[i]) begin
            if (gaps) while ($urandom_range(0, 2) == 0) idle();
            drive(1'b1, i == 0, 1'b0, msg_q[i], at);
            push(at, msg_q[i], i == 0, 1'b0, mtag);
        end
        for (int j = 0; j < P; j++) begin
            drive(1'b1, 1'b0, j == P - 1, pad_fill[15 - j*W -: W], at);
            push(at, chk[15 - j*W -: W], 1'b0, j == P - 1, ctag);
        end
    endtask

    task automatic random_msg(input int len);
        msg_q.delete();
        for (int i = 0; i < len; i++) msg_q.push_back(W'($urandom));
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        exp_t it;
        if (run && !rst) begin
            if (out_valid) begin
                n_chk++;
                if (sb.size() == 0) begin
                    n_bad++;
                    $display("FAIL R8: unexpected output at cyc=%0d data=%h, expected no output",
                             cyc, out_data);
                end else begin
                    it = sb.pop_front();
                    if (it.cyc != cyc || out_data !== it.data || out_start !== it.s || out_end !== it.e) begin
                        n_bad++;
                        $display("FAIL %s (R5 timing): cyc=%0d data=%h s=%0b e=%0b, expected cyc=%0d data=%h s=%0b e=%0b",
                                 it.tag, cyc, out_data, out_start, out_end, it.cyc, it.data, it.s, it.e);
                    end
                end
            end else if (sb.size() > 0 && sb[0].cyc < cyc) begin
                it = sb.pop_front();
                n_chk++; n_bad++;
                $display("FAIL R5: missing output, actual none at cyc=%0d, expected data=%h at cyc=%0d",
                         cyc, it.data, it.cyc);
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] vec;
        logic [15:0] got;
        // R10: outputs quiet during reset.
        repeat (4) begin
            @(negedge clk);
            n_chk++;
            if (out_valid !== 1'b0 || out_start !== 1'b0 || out_end !== 1'b0) begin
                n_bad++;
                $display("FAIL R10: v/s/e=%0b%0b%0b, expected 000", out_valid, out_start, out_end);
            end
        end
        @(negedge clk); rst = 1'b0; run = 1'b1;
        repeat (2) idle();

        // R4: known message, plus the reference value itself.
        vec = 32'h5000_0300;
        msg_q.delete();
        for (int k = 0; k < 32 / W; k++) msg_q.push_back(vec[31 - k*W -: W]);
        got = ref_chk();
        n_chk++;
        if (got !== 16'h5B57) begin
            n_bad++;
            $display("FAIL R4: reference checksum=%h, expected 5b57", got);
        end
        send_frame(1'b0, 16'h0000, "R6", "R4");
        repeat (3) idle();

        // R1 and R8: random lengths with idle gaps among message words.
        for (int f = 0; f < 6; f++) begin
            random_msg($urandom_range(1, 9));
            send_frame(1'b1, 16'h0000, "R8", "R1");
            repeat ($urandom_range(0, 3)) idle();
        end

        // R3 and R6: back-to-back frames without gaps.
        for (int f = 0; f < 3; f++) begin
            random_msg($urandom_range(2, 6));
            send_frame(1'b0, 16'h0000, "R6", "R3");
        end

        // R7: nonzero padding content is overwritten.
        random_msg(4);
        send_frame(1'b0, 16'hA5C3, "R6", "R7");

        // R2: single-word message right after another frame.
        random_msg(1);
        send_frame(1'b0, 16'h0000, "R6", "R2");
        idle();

        // R9: abandoned partial frame, then a fresh start.
        begin
            int unsigned at;
            for (int i = 0; i < 3; i++) begin
                logic [W-1:0] d;
                d = W'($urandom);
                drive(1'b1, i == 0, 1'b0, d, at);
                push(at, d, i == 0, 1'b0, "R9");
            end
        end
        random_msg(5);
        send_frame(1'b0, 16'h0000, "R9", "R9");

        repeat (LAT + 6) idle();
        // R5: every expected word was delivered.
        n_chk++;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R5: %0d words undelivered, expected 0", sb.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule